// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks; the two clocks may also be the same net. Words enter on write-clock edges under a pair of write enables (one active low, one active high). They leave through a registered output on read-clock edges under two active-low read enables. The default word is 9 bits wide and the depth is a power-of-two parameter.

Four active-low status outputs report the fill state. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The almost thresholds come from two offset inputs, N for almost-empty and M for almost-full, with single-word granularity. These inputs are held by a separate offset register block, which loads 7 into both after reset. Each domain sees the other's pointer as Gray code through a two-flop synchronizer, so a flag can clear a few cycles late. A flag never clears early.

Top module: `dcfifo_prog_flags`

## Requirements
- R1: A word is stored on a write-clock rising edge only when `wen1_ni` is 0, `wen2_i` is 1 and `full_no` is 1. Holding both enables active stores one word on every such edge.
- R2: A word is taken on a read-clock rising edge only when `ren1_ni` and `ren2_ni` are both 0 and `empty_no` is 1. On any other read edge `rdata_o` keeps its value, so an empty FIFO keeps showing the last word read.
- R3: Write attempts while `full_no` is 0 are ignored, and the stored contents stay unchanged.
- R4: Words come out in the order they were accepted, without loss or duplication, for unrelated write and read clock periods.
- R5: `empty_no` is updated only by read-clock edges. It is 1 only when at least one word is held. After both sides have been idle for 8 read cycles, it equals (occupancy != 0).
- R6: `full_no` is updated only by write-clock edges. It is 1 only when fewer than DEPTH words are held. After both sides have been idle, it equals (occupancy != DEPTH).
- R7: `almost_empty_no` is a read-domain flag. It is 0 when N (`ae_off_i`) or fewer words are held, and 1 once N+1 or more are held. It is 1 only when the true occupancy exceeds N.
- R8: `almost_full_no` is a write-domain flag. It is 0 when at least DEPTH−M words are held (M = `af_off_i`), and 1 once more than M locations are free. It is 1 only when the true occupancy is below DEPTH−M.
- R9: While `rst_ni` is 0, the FIFO is emptied. `empty_no` and `almost_empty_no` go to 0, `full_no` and `almost_full_no` go to 1, and `rdata_o` goes to 0.
- R10: After a write into an empty FIFO, `empty_no` rises within 4 read-clock edges. The next accepted read places that word on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wen1_ni | input | 1 | Write enable, active low |
| wen2_i | input | 1 | Write enable, active high |
| wdata_i | input | WIDTH | Write data |
| ren1_ni | input | 1 | Read enable, active low |
| ren2_ni | input | 1 | Read enable, active low |
| ae_off_i | input | log2(DEPTH) | Almost-empty offset N |
| af_off_i | input | log2(DEPTH) | Almost-full offset M |
| rdata_o | output | WIDTH | Registered read data |
| empty_no | output | 1 | Empty flag, active low, read domain |
| almost_empty_no | output | 1 | Almost-empty flag, active low, read domain |
| full_no | output | 1 | Full flag, active low, write domain |
| almost_full_no | output | 1 | Almost-full flag, active low, write domain |

## Verification
The bench uses WIDTH 9 and DEPTH 16, which makes 4-bit offsets. Every occupancy from 0 to 16 can then be visited, filling and draining, under four offset pairs: the reset pair 7/7, both offsets at 0, an asymmetric pair, and N=15 with M=1. This reaches the threshold extremes of both almost flags. The small depth also keeps full, with overflow attempts, only sixteen writes away. It lets long streaming runs with an 8 ns write clock and an 11 ns read clock wrap the pointers many times. During those runs, every flag is checked against the true occupancy in the direction that synchronizer lag must never violate.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] ram_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = ram_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl import dcf_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_i,
  input  logic [PW-1:0] rgray_s_i,
  input  logic [AW-1:0] af_off_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_no,
  output logic          afull_no
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wbin_d, rbin_s, used_d, af_lim;

  assign we_o    = !wen1_ni && wen2_i && full_no;
  assign waddr_o = wbin_o[AW-1:0];
  assign wbin_d  = wbin_o + PW'(we_o);
  assign rbin_s  = PW'(gray2bin(32'(rgray_s_i)));
  // occupancy seen from this side is never below the true value
  assign used_d  = wbin_d - rbin_s;
  assign af_lim  = DEPTH_P - {1'b0, af_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_o   <= '0;
      wgray_o  <= '0;
      full_no  <= 1'b1;
      afull_no <= 1'b1;
    end else begin
      wbin_o   <= wbin_d;
      wgray_o  <= PW'(bin2gray(32'(wbin_d)));
      full_no  <= (used_d != DEPTH_P);
      afull_no <= (used_d < af_lim);
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl import dcf_pkg::*; #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ren1_ni,
  input  logic             ren2_ni,
  input  logic [PW-1:0]    wgray_s_i,
  input  logic [AW-1:0]    ae_off_i,
  input  logic [WIDTH-1:0] mem_rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [PW-1:0]    rbin_o,
  output logic [PW-1:0]    rgray_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_no,
  output logic             aempty_no
);
  logic          rd_go;
  logic [PW-1:0] rbin_d, wbin_s, used_d;

  assign rd_go   = !ren1_ni && !ren2_ni && empty_no;
  assign raddr_o = rbin_o[AW-1:0];
  assign rbin_d  = rbin_o + PW'(rd_go);
  assign wbin_s  = PW'(gray2bin(32'(wgray_s_i)));
  // occupancy seen from this side is never above the true value
  assign used_d  = wbin_s - rbin_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_o    <= '0;
      rgray_o   <= '0;
      rdata_o   <= '0;
      empty_no  <= 1'b0;
      aempty_no <= 1'b0;
    end else begin
      rbin_o    <= rbin_d;
      rgray_o   <= PW'(bin2gray(32'(rbin_d)));
      if (rd_go) rdata_o <= mem_rdata_i;
      empty_no  <= (used_d != '0);
      aempty_no <= (used_d > {1'b0, ae_off_i});
    end
  end
endmodule

// File: rtl/dcfifo_prog_flags.sv
`timescale 1ns/1ps
module dcfifo_prog_flags #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wen1_ni,
  input  logic             wen2_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             ren1_ni,
  input  logic             ren2_ni,
  input  logic [AW-1:0]    ae_off_i,
  input  logic [AW-1:0]    af_off_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_no,
  output logic             almost_empty_no,
  output logic             full_no,
  output logic             almost_full_no
);
  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [WIDTH-1:0] mem_rdata;
  logic [PW-1:0]    wr_ptr, wr_gray, wr_gray_s;
  logic [PW-1:0]    rd_ptr, rd_gray, rd_gray_s;

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .wen1_ni   (wen1_ni),
    .wen2_i    (wen2_i),
    .rgray_s_i (rd_gray_s),
    .af_off_i  (af_off_i),
    .we_o      (mem_we),
    .waddr_o   (mem_waddr),
    .wbin_o    (wr_ptr),
    .wgray_o   (wr_gray),
    .full_no   (full_no),
    .afull_no  (almost_full_no)
  );

  dcf_sync #(.W(PW)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rd_gray),
    .q_o    (rd_gray_s)
  );

  dcf_sync #(.W(PW)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wr_gray),
    .q_o    (wr_gray_s)
  );

  dcf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (wdata_i),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  dcf_rd_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .ren1_ni     (ren1_ni),
    .ren2_ni     (ren2_ni),
    .wgray_s_i   (wr_gray_s),
    .ae_off_i    (ae_off_i),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (mem_raddr),
    .rbin_o      (rd_ptr),
    .rgray_o     (rd_gray),
    .rdata_o     (rdata_o),
    .empty_no    (empty_no),
    .aempty_no   (almost_empty_no)
  );
endmodule

// File: rtl/dcfifo_prog_flags_chk.sv
`timescale 1ns/1ps
module dcfifo_prog_flags_chk #(
  parameter int WIDTH = 9,
  parameter int PW    = 5
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             wen1_ni,
  input logic             wen2_i,
  input logic             ren1_ni,
  input logic             ren2_ni,
  input logic             full_no,
  input logic             almost_full_no,
  input logic             empty_no,
  input logic             almost_empty_no,
  input logic [WIDTH-1:0] rdata_o,
  input logic [PW-1:0]    wptr,
  input logic [PW-1:0]    rptr
);
  assert_write_gate_R1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wen1_ni || !wen2_i) |=> $stable(wptr));

  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wptr));

  assert_no_underflow_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> ($stable(rptr) && $stable(rdata_o)));

  assert_read_gate_R2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ren1_ni || ren2_ni) |=> $stable(rdata_o));

  assert_empty_in_ae_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no);

  assert_full_in_af_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !almost_full_no);
endmodule

bind dcfifo_prog_flags dcfifo_prog_flags_chk #(.WIDTH(WIDTH), .PW(PW)) u_chk (
  .wclk_i          (wclk_i),
  .rclk_i          (rclk_i),
  .rst_ni          (rst_ni),
  .wen1_ni         (wen1_ni),
  .wen2_i          (wen2_i),
  .ren1_ni         (ren1_ni),
  .ren2_ni         (ren2_ni),
  .full_no         (full_no),
  .almost_full_no  (almost_full_no),
  .empty_no        (empty_no),
  .almost_empty_no (almost_empty_no),
  .rdata_o         (rdata_o),
  .wptr            (wr_ptr),
  .rptr            (rd_ptr)
);

// File: tb/dcfifo_prog_flags_tb.sv
`timescale 1ns/1ps
module dcfifo_prog_flags_tb;
  localparam int W  = 9;
  localparam int D  = 16;
  localparam int AW = 4;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          wen1 = 1'b1, wen2 = 1'b0, ren1 = 1'b1, ren2 = 1'b1;
  logic [W-1:0]  wdata = '0;
  logic [AW-1:0] ae_off = 4'd7, af_off = 4'd7;
  logic [W-1:0]  rdata;
  logic          empty_n, aempty_n, full_n, afull_n;

  int n_tests = 0, n_fail = 0;
  int wr_tot = 0, rd_tot = 0;
  int cur_n = 7, cur_m = 7;
  int seed = 1;
  bit mon_on = 0;
  logic [W-1:0] last_rd = '0;
  logic [W-1:0] q[$];

  always #4   wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  dcfifo_prog_flags #(.WIDTH(W), .DEPTH(D)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wen1_ni(wen1), .wen2_i(wen2), .wdata_i(wdata),
    .ren1_ni(ren1), .ren2_ni(ren2),
    .ae_off_i(ae_off), .af_off_i(af_off),
    .rdata_o(rdata), .empty_no(empty_n), .almost_empty_no(aempty_n),
    .full_no(full_n), .almost_full_no(afull_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  task automatic wr_try(input logic e1, input logic e2, input logic [W-1:0] d, output bit acc);
    logic fs;
    @(negedge wclk);
    wen1 = e1; wen2 = e2; wdata = d; fs = full_n;
    @(posedge wclk);
    acc = !e1 && e2 && fs;
    if (acc) begin q.push_back(d); wr_tot++; end
    #1 wen1 = 1'b1; wen2 = 1'b0;
  endtask

  task automatic rd_try(input logic e1, input logic e2, output bit acc);
    logic es;
    logic [W-1:0] exp;
    @(negedge rclk);
    ren1 = e1; ren2 = e2; es = empty_n;
    @(posedge rclk);
    acc = !e1 && !e2 && es;
    exp = last_rd;
    if (acc) begin exp = q.pop_front(); rd_tot++; end
    #1 ren1 = 1'b1; ren2 = 1'b1;
    @(negedge rclk);
    if (acc) check(rdata == exp, "R4 order", int'(rdata), int'(exp));
    else     check(rdata == exp, "R2 hold", int'(rdata), int'(exp));
    last_rd = exp;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic check_flags(input int occ);
    check(empty_n  == (occ != 0),        "R5 empty",  int'(empty_n),  int'(occ != 0));
    check(aempty_n == (occ > cur_n),     "R7 aempty", int'(aempty_n), int'(occ > cur_n));
    check(full_n   == (occ != D),        "R6 full",   int'(full_n),   int'(occ != D));
    check(afull_n  == (occ < D - cur_m), "R8 afull",  int'(afull_n),  int'(occ < D - cur_m));
  endtask

  task automatic set_off(input int n, input int m);
    @(negedge wclk);
    ae_off = AW'(n); af_off = AW'(m); cur_n = n; cur_m = m;
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 1'b0;
    repeat (3) @(negedge rclk);
    check(rdata == '0, "R9 rdata", int'(rdata), 0);
    check(empty_n == 1'b0 && aempty_n == 1'b0, "R9 empty flags", int'({empty_n, aempty_n}), 0);
    check(full_n == 1'b1 && afull_n == 1'b1, "R9 full flags", int'({full_n, afull_n}), 3);
    q.delete(); wr_tot = 0; rd_tot = 0; last_rd = '0;
    @(negedge wclk);
    rst_n = 1'b1;
    repeat (2) @(negedge rclk);
  endtask

  // conservative-direction flag checks during streaming
  always @(negedge wclk) if (mon_on) begin
    if (full_n)  check(wr_tot - rd_tot < D, "R6 early clear", wr_tot - rd_tot, D - 1);
    if (afull_n) check(wr_tot - rd_tot < D - cur_m, "R8 early clear", wr_tot - rd_tot, D - cur_m - 1);
  end
  always @(negedge rclk) if (mon_on) begin
    if (empty_n)  check(wr_tot - rd_tot >= 1, "R5 early clear", wr_tot - rd_tot, 1);
    if (aempty_n) check(wr_tot - rd_tot > cur_n, "R7 early clear", wr_tot - rd_tot, cur_n + 1);
  end

  task automatic stream(input int count, input int wthr, input int rthr);
    mon_on = 1;
    fork
      begin
        for (int i = 0; i < count; i++) begin
          bit acc;
          acc = 0;
          while (!acc) begin
            if (rnd() < wthr) wr_try(1'b0, 1'b1, W'(i * 29 + 3), acc);
            else @(posedge wclk);
          end
        end
      end
      begin
        int got;
        got = 0;
        while (got < count) begin
          bit acc;
          if (rnd() < rthr) begin
            rd_try(1'b0, 1'b0, acc);
            if (acc) got++;
          end else @(posedge rclk);
        end
      end
    join
    mon_on = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge wclk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit acc;
    int pairs_n[4] = '{7, 0, 3, 15};
    int pairs_m[4] = '{7, 0, 12, 1};

    // R9: reset state with the power-on offsets
    do_reset();
    settle();
    check_flags(0);

    // R1: each write enable alone is not enough
    wr_try(1'b0, 1'b0, 9'h111, acc);
    wr_try(1'b1, 1'b1, 9'h122, acc);
    wr_try(1'b1, 1'b0, 9'h133, acc);
    settle();
    check(empty_n == 1'b0, "R1 gated write", int'(empty_n), 0);
    wr_try(1'b0, 1'b1, 9'h0A5, acc);
    check(acc, "R1 write accepted", int'(acc), 1);
    settle();
    check(empty_n == 1'b1, "R1 stored", int'(empty_n), 1);
    // R2: one read enable alone does not pop
    rd_try(1'b0, 1'b1, acc);
    rd_try(1'b1, 1'b0, acc);
    settle();
    check(empty_n == 1'b1, "R2 gated read", int'(empty_n), 1);
    rd_try(1'b0, 1'b0, acc);
    check(acc, "R2 read accepted", int'(acc), 1);

    // R5..R8 sweeps up and down, R3 overflow, R2 underflow
    for (int p = 0; p < 4; p++) begin
      set_off(pairs_n[p], pairs_m[p]);
      for (int k = 0; k <= D; k++) begin
        settle();
        check_flags(k);
        if (k < D) wr_try(1'b0, 1'b1, W'(k * 37 + p * 5), acc);
      end
      for (int x = 0; x < 3; x++) begin
        wr_try(1'b0, 1'b1, 9'h1FF, acc);
        check(!acc, "R3 write while full", int'(acc), 0);
      end
      settle();
      check_flags(D);
      for (int k = D; k > 0; k--) begin
        rd_try(1'b0, 1'b0, acc);
        settle();
        check_flags(k - 1);
      end
      for (int x = 0; x < 3; x++) rd_try(1'b0, 1'b0, acc);
    end

    // R10: first-word latency into an empty FIFO
    set_off(7, 7);
    for (int t = 0; t < 4; t++) begin
      int lat;
      bit seen;
      wr_try(1'b0, 1'b1, W'(9'h140 + t * 3), acc);
      lat = 0; seen = 0;
      while (!seen && lat < 8) begin
        @(posedge rclk); lat++;
        @(negedge rclk); seen = empty_n;
      end
      check(seen && lat <= 4, "R10 empty latency", lat, 4);
      rd_try(1'b0, 1'b0, acc);
      check(acc, "R10 first word read", int'(acc), 1);
    end

    // R4: independent clocks, both speed ratios, pointer wrap
    set_off(3, 5);
    stream(400, 230, 120);
    stream(400, 100, 240);
    settle();
    check_flags(0);

    // R9: reset in the middle of traffic empties the FIFO
    for (int i = 0; i < 10; i++) wr_try(1'b0, 1'b1, W'(i + 60), acc);
    do_reset();
    settle();
    check_flags(0);
    rd_try(1'b0, 1'b0, acc);
    check(!acc, "R9 empty after reset", int'(acc), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule